// File: doc/BRIEF.md
# Quad-data-rate burst-four SRAM model

This block is a synthesizable, reduced-size model of the memory side of a quad-data-rate static RAM. It has a read port and a write port that work independently, and both take their command address from one shared address bus. Every access transfers a burst of four words. The double-data-rate data pins are modelled inside one clock domain. In each cycle of the input clock, a "rise" lane carries the even beat of a pair and a "fall" lane carries the odd beat.

A write starts when its active-low select is low at a rising clock edge. The rise and fall lanes of that command cycle carry burst words 0 and 1. The lanes of the following cycle carry words 2 and 3. Every lane has its own active-low byte enables. A read starts when its active-low select is low at a rising edge. After a fixed latency the block returns the four words as two beat pairs, together with a valid flag that takes the place of a tri-state driver. Each burst address selects four consecutive words, stored at index {address, beat}. A port is busy during the second cycle of its own burst. A read and a write to the same address that start in the same cycle are coherent: the read returns the newly written bytes.

Top module: `qdr_burst4_mem`

## Requirements
- R1: When write select is low at a rising edge, the rise and fall lanes are stored at words {addr,0} and {addr,1}. The lanes of the next cycle are stored at {addr,2} and {addr,3}, using the address from the command cycle.
- R2: Byte enables are active low and apply per lane and per beat. Enable bit b covers data bits [9b+8:9b]. A byte whose enable is high keeps its stored value.
- R3: While write select is high, and outside the second cycle of a write burst, the data, address and enable inputs change no stored word.
- R4: When read select is low at a rising edge in cycle c, rd_valid is high with words {addr,0}/{addr,1} on the rise/fall outputs in cycle c+RD_LAT. Words {addr,2}/{addr,3} follow in cycle c+RD_LAT+1 (RD_LAT defaults to 2).
- R5: While no read burst is being delivered, rd_valid is low and both read data outputs are zero.
- R6: A select that is low during the second cycle of that port's own burst is ignored. It starts no burst, and its address is not used.
- R7: Raising read select during a burst does not cut the burst short. Reads started in cycles c and c+2 give four consecutive valid cycles.
- R8: If a read and a write to the same address start in the same cycle, the read returns the written bytes for enabled bytes and the previous contents for disabled bytes. A read that starts one cycle after a write to the same address returns the fully written burst.
- R9: While reset is asserted, and after it is released, no read burst is in flight. rd_valid is low even if a read was in progress when reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; each cycle carries one rise and one fall beat |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| addr | input | ADDR_W | Shared burst address |
| wr_rise | input | BYTE_W*N_BYTES | Write data, even beat of the current pair |
| wr_fall | input | BYTE_W*N_BYTES | Write data, odd beat of the current pair |
| be_rise_n | input | N_BYTES | Active-low byte enables for wr_rise |
| be_fall_n | input | N_BYTES | Active-low byte enables for wr_fall |
| rd_rise | output | BYTE_W*N_BYTES | Read data, even beat of the current pair |
| rd_fall | output | BYTE_W*N_BYTES | Read data, odd beat of the current pair |
| rd_valid | output | 1 | High while a read beat pair is presented |

## Verification
A read command driven in cycle c must show words 0 and 1 in cycle c+RD_LAT and words 2 and 3 one cycle later. In the cycle after that, the outputs must be idle, unless a back-to-back read keeps them busy. The bench drives every input on the falling edge and samples at the falling edge. It counts the cycles from the command and calls each check on exactly the falling edge of cycle c+RD_LAT, c+RD_LAT+1 or c+RD_LAT+2. A write takes effect on the edge that samples it, so a read issued in any later cycle sees it. The bench keeps a shadow array, updates it in the write's command cycle, and takes each read's expected values from that array.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned BURST_LEN  = 4;
  localparam int unsigned LANES      = 2;
  localparam int unsigned BEAT_SEL_W = $clog2(BURST_LEN);

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } burst_ph_e;
endpackage

// File: rtl/qdr_burst_seq.sv
module qdr_burst_seq
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              xfer,
  output burst_ph_e         phase,
  output logic [ADDR_W-1:0] addr_eff
);
  burst_ph_e         ph_q, ph_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              start;

  always_comb begin
    start   = (ph_q == PH_FIRST) && !sel_n;
    ph_d    = start ? PH_SECOND : PH_FIRST;
    addr_en = start;
    addr_d  = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FIRST;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign xfer     = start || (ph_q == PH_SECOND);
  assign phase    = ph_q;
  assign addr_eff = (ph_q == PH_SECOND) ? addr_q : addr_in;

  AST_SECOND_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SECOND) |-> $past(!sel_n)); // R1
  AST_NO_RESTART_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SECOND) |=> (ph_q == PH_FIRST)); // R6
  AST_BURST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SECOND) |-> (addr_eff == $past(addr_in))); // R1
endmodule

// File: rtl/qdr_burst_array.sv
module qdr_burst_array
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned BYTE_W  = 9,
  parameter int unsigned N_BYTES = 4
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic                                wr_half,
  input  logic [LANES-1:0][BYTE_W*N_BYTES-1:0] wr_data,
  input  logic [LANES-1:0][N_BYTES-1:0]        wr_be_n,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic                                rd_half,
  output logic [LANES-1:0][BYTE_W*N_BYTES-1:0] rd_data
);
  localparam int unsigned DATA_W = BYTE_W * N_BYTES;
  localparam int unsigned IDX_W  = ADDR_W + BEAT_SEL_W;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  logic [DATA_W-1:0]            mem [DEPTH];
  logic [LANES-1:0][IDX_W-1:0]  wr_idx;
  logic [LANES-1:0][IDX_W-1:0]  rd_idx;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign wr_idx[gl]  = {wr_addr, wr_half, 1'(gl)};
    assign rd_idx[gl]  = {rd_addr, rd_half, 1'(gl)};
    assign rd_data[gl] = mem[rd_idx[gl]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        for (int b = 0; b < N_BYTES; b++) begin
          if (!wr_be_n[l][b])
            mem[wr_idx[l]][b*BYTE_W +: BYTE_W] <= wr_data[l][b*BYTE_W +: BYTE_W];
        end
      end
    end
  end
endmodule

// File: rtl/qdr_wr_fwd.sv
module qdr_wr_fwd
  import qdr_pkg::*;
#(
  parameter int unsigned BYTE_W  = 9,
  parameter int unsigned N_BYTES = 4
) (
  input  logic                                 hit,
  input  logic [LANES-1:0][BYTE_W*N_BYTES-1:0] arr_data,
  input  logic [LANES-1:0][BYTE_W*N_BYTES-1:0] wr_data,
  input  logic [LANES-1:0][N_BYTES-1:0]        wr_be_n,
  output logic [LANES-1:0][BYTE_W*N_BYTES-1:0] merged
);
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_byte
      assign merged[gl][gb*BYTE_W +: BYTE_W] = (hit && !wr_be_n[gl][gb])
                                             ? wr_data[gl][gb*BYTE_W +: BYTE_W]
                                             : arr_data[gl][gb*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
  import qdr_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned RD_LAT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_half,
  input  logic [LANES-1:0][DATA_W-1:0] in_data,
  output logic                         out_valid,
  output logic                         out_half,
  output logic [LANES-1:0][DATA_W-1:0] out_data
);
  logic [RD_LAT-1:0]                         vld_q, vld_d;
  logic [RD_LAT-1:0]                         half_q, half_d;
  logic [RD_LAT-1:0][LANES-1:0][DATA_W-1:0]  data_q, data_d;
  logic                                      pipe_en;

  always_comb begin
    pipe_en   = in_valid || (|vld_q);
    vld_d[0]  = in_valid;
    half_d[0] = in_valid && in_half;
    data_d[0] = in_valid ? in_data : '0;
    for (int s = 1; s < RD_LAT; s++) begin
      vld_d[s]  = vld_q[s-1];
      half_d[s] = half_q[s-1];
      data_d[s] = data_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      half_q <= '0;
      data_q <= '0;
    end else if (pipe_en) begin
      vld_q  <= vld_d;
      half_q <= half_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q[RD_LAT-1];
  assign out_half  = half_q[RD_LAT-1];
  assign out_data  = data_q[RD_LAT-1];

  AST_PAIR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_half) |=> (out_valid && out_half)); // R7
  AST_FIRST_PAIR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_half); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0)); // R5
endmodule

// File: rtl/qdr_burst4_mem.sv
module qdr_burst4_mem
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned BYTE_W  = 9,
  parameter int unsigned N_BYTES = 4,
  parameter int unsigned RD_LAT  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_sel_n,
  input  logic                      wr_sel_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W*N_BYTES-1:0] wr_rise,
  input  logic [BYTE_W*N_BYTES-1:0] wr_fall,
  input  logic [N_BYTES-1:0]        be_rise_n,
  input  logic [N_BYTES-1:0]        be_fall_n,
  output logic [BYTE_W*N_BYTES-1:0] rd_rise,
  output logic [BYTE_W*N_BYTES-1:0] rd_fall,
  output logic                      rd_valid
);
  localparam int unsigned DATA_W = BYTE_W * N_BYTES;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // per-port burst sequencers on the shared address bus
  logic              wr_xfer, rd_xfer;
  burst_ph_e         wr_phase, rd_phase;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_half, rd_half;

  qdr_burst_seq #(.ADDR_W(ADDR_W)) u_wr_seq (
    .clk(clk), .rst_n(rst_core_n), .sel_n(wr_sel_n), .addr_in(addr),
    .xfer(wr_xfer), .phase(wr_phase), .addr_eff(wr_addr)
  );

  qdr_burst_seq #(.ADDR_W(ADDR_W)) u_rd_seq (
    .clk(clk), .rst_n(rst_core_n), .sel_n(rd_sel_n), .addr_in(addr),
    .xfer(rd_xfer), .phase(rd_phase), .addr_eff(rd_addr)
  );

  assign wr_half = (wr_phase == PH_SECOND);
  assign rd_half = (rd_phase == PH_SECOND);

  // lane 0 = rise beat, lane 1 = fall beat
  logic [LANES-1:0][DATA_W-1:0]  wr_lanes, arr_lanes, fwd_lanes;
  logic [LANES-1:0][N_BYTES-1:0] be_lanes;
  logic                          fwd_hit;

  assign wr_lanes = {wr_fall, wr_rise};
  assign be_lanes = {be_fall_n, be_rise_n};
  assign fwd_hit  = wr_xfer && rd_xfer && (wr_addr == rd_addr) && (wr_half == rd_half);

  qdr_burst_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_array (
    .clk(clk), .wr_en(wr_xfer), .wr_addr(wr_addr), .wr_half(wr_half),
    .wr_data(wr_lanes), .wr_be_n(be_lanes),
    .rd_addr(rd_addr), .rd_half(rd_half), .rd_data(arr_lanes)
  );

  qdr_wr_fwd #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_fwd (
    .hit(fwd_hit), .arr_data(arr_lanes), .wr_data(wr_lanes),
    .wr_be_n(be_lanes), .merged(fwd_lanes)
  );

  logic                         out_half;
  logic [LANES-1:0][DATA_W-1:0] out_lanes;

  qdr_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_core_n), .in_valid(rd_xfer), .in_half(rd_half),
    .in_data(fwd_lanes), .out_valid(rd_valid), .out_half(out_half),
    .out_data(out_lanes)
  );

  assign rd_rise = out_lanes[0];
  assign rd_fall = out_lanes[1];

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_core_n |=> !rd_valid); // R9
  AST_HIT_ONLY_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_core_n)
    fwd_hit |-> (!rd_half || $past(!rd_sel_n))); // R8
endmodule

// File: tb/test_qdr_burst4_mem.sv
module test_qdr_burst4_mem;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NB     = 4;
  localparam int unsigned DW     = 36;
  localparam int unsigned RD_LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_sel_n, wr_sel_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0] wr_rise, wr_fall, rd_rise, rd_fall;
  logic [NB-1:0] be_rise_n, be_fall_n;
  logic          rd_valid;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [DW-1:0] shadow [64];

  always #2 clk = ~clk;

  qdr_burst4_mem #(.ADDR_W(ADDR_W), .BYTE_W(9), .N_BYTES(NB), .RD_LAT(RD_LAT)) i_qdr_burst4_mem (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .be_rise_n(be_rise_n), .be_fall_n(be_fall_n),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .rd_valid(rd_valid)
  );

  // {addr[35:32], seed[31:16], active-low enables: beat k in [4k+3:4k]}
  localparam logic [35:0] VEC [8] = '{
    {4'h3, 16'h1234, 16'h0000},
    {4'h3, 16'hBEEF, 16'hFFFF},
    {4'h5, 16'h0F0F, 16'h5A5A},
    {4'hC, 16'hA5A5, 16'h0F0F},
    {4'h0, 16'h7777, 16'hF0F0},
    {4'hF, 16'h1357, 16'h8421},
    {4'h8, 16'hFFFF, 16'h1248},
    {4'h5, 16'h2468, 16'h0000}
  };

  function automatic logic [DW-1:0] pat(input logic [15:0] seed, input int beat);
    logic [15:0] bt = 16'(beat);
    return {seed[3:0] ^ bt[3:0], seed ^ (bt * 16'h1357), seed + bt + 16'h0101};
  endfunction

  task automatic shadow_apply(input logic [3:0] a, input logic [15:0] seed, input logic [15:0] m);
    for (int bt = 0; bt < 4; bt++) begin
      logic [DW-1:0] w = pat(seed, bt);
      for (int b = 0; b < NB; b++)
        if (!m[4*bt+b]) shadow[{a, 2'(bt)}][9*b +: 9] = w[9*b +: 9];
    end
  endtask

  task automatic idle_inputs();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0;
    wr_rise = '0; wr_fall = '0; be_rise_n = '1; be_fall_n = '1;
  endtask

  task automatic check_pair(input logic ev, input logic [DW-1:0] er, input logic [DW-1:0] ef,
                            input string req);
    vectors++;
    if (rd_valid !== ev || rd_rise !== er || rd_fall !== ef) begin
      miscompares++;
      $display("FAIL %s: got valid=%b rise=%h fall=%h, expected valid=%b rise=%h fall=%h",
               req, rd_valid, rd_rise, rd_fall, ev, er, ef);
    end
  endtask

  task automatic write_burst(input logic [3:0] a, input logic [15:0] seed, input logic [15:0] m);
    @(negedge clk);
    wr_sel_n = 1'b0; addr = a; wr_rise = pat(seed, 0); wr_fall = pat(seed, 1);
    be_rise_n = m[3:0]; be_fall_n = m[7:4];
    @(negedge clk);
    wr_sel_n = 1'b1; addr = ~a; wr_rise = pat(seed, 2); wr_fall = pat(seed, 3);
    be_rise_n = m[11:8]; be_fall_n = m[15:12];
    shadow_apply(a, seed, m);
    @(negedge clk);
    idle_inputs();
  endtask

  // command in cycle c; beat pairs checked at c+RD_LAT and c+RD_LAT+1, idle after
  task automatic read_check(input logic [3:0] a, input string req);
    logic [DW-1:0] e [4];
    for (int b = 0; b < 4; b++) e[b] = shadow[{a, 2'(b)}];
    @(negedge clk);
    rd_sel_n = 1'b0; addr = a;
    @(negedge clk);
    rd_sel_n = 1'b1; addr = ~a;
    repeat (RD_LAT - 1) @(negedge clk);
    check_pair(1'b1, e[0], e[1], req);
    @(negedge clk);
    check_pair(1'b1, e[2], e[3], req);
    @(negedge clk);
    check_pair(1'b0, '0, '0, "R5 idle after burst");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_pair(1'b0, '0, '0, "R9 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pair(1'b0, '0, '0, "R9 after reset");

    // preload every address with full writes
    for (int a = 0; a < 16; a++) write_burst(4'(a), 16'hA000 + 16'(a), 16'h0000);

    // vector table: write with masks, read back (R1 R2 R4 R5)
    for (int i = 0; i < 8; i++) begin
      write_burst(VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);
      read_check(VEC[i][35:32], "R1 R2 R4 vector");
    end

    // R3: write select high, other inputs active
    @(negedge clk);
    addr = 4'h6; wr_rise = '1; wr_fall = '1; be_rise_n = '0; be_fall_n = '0;
    @(negedge clk);
    idle_inputs();
    read_check(4'h6, "R3 deselected write");

    // R6: write select low again in second cycle of a write burst
    @(negedge clk);
    wr_sel_n = 1'b0; addr = 4'h6; wr_rise = pat(16'h4242, 0); wr_fall = pat(16'h4242, 1);
    be_rise_n = '0; be_fall_n = '0;
    @(negedge clk);
    wr_sel_n = 1'b0; addr = 4'h7; wr_rise = pat(16'h4242, 2); wr_fall = pat(16'h4242, 3);
    shadow_apply(4'h6, 16'h4242, 16'h0000);
    @(negedge clk);
    idle_inputs();
    read_check(4'h6, "R6 burst kept address");
    read_check(4'h7, "R6 busy write ignored");

    // R6 R7: read at c, ignored select at c+1, accepted read at c+2
    begin : b2b
      logic [DW-1:0] ea [4];
      logic [DW-1:0] eb [4];
      for (int b = 0; b < 4; b++) begin
        ea[b] = shadow[{4'h3, 2'(b)}];
        eb[b] = shadow[{4'hC, 2'(b)}];
      end
      @(negedge clk); rd_sel_n = 1'b0; addr = 4'h3;
      @(negedge clk); rd_sel_n = 1'b0; addr = 4'hC;
      @(negedge clk); rd_sel_n = 1'b0; addr = 4'hC;
      check_pair(1'b1, ea[0], ea[1], "R7 first read pair 0");
      @(negedge clk); idle_inputs();
      check_pair(1'b1, ea[2], ea[3], "R6 R7 first read pair 1");
      @(negedge clk);
      check_pair(1'b1, eb[0], eb[1], "R7 second read pair 0");
      @(negedge clk);
      check_pair(1'b1, eb[2], eb[3], "R7 second read pair 1");
      @(negedge clk);
      check_pair(1'b0, '0, '0, "R5 idle after back-to-back");
    end

    // R8: read and write to the same address start together
    begin : coll
      logic [DW-1:0] e [4];
      @(negedge clk);
      rd_sel_n = 1'b0; wr_sel_n = 1'b0; addr = 4'h9;
      wr_rise = pat(16'h7E11, 0); wr_fall = pat(16'h7E11, 1);
      be_rise_n = 4'b0101; be_fall_n = 4'b0011;
      shadow_apply(4'h9, 16'h7E11, 16'h0C35);
      for (int b = 0; b < 4; b++) e[b] = shadow[{4'h9, 2'(b)}];
      @(negedge clk);
      rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = 4'h2;
      wr_rise = pat(16'h7E11, 2); wr_fall = pat(16'h7E11, 3);
      be_rise_n = 4'b1100; be_fall_n = 4'b0000;
      @(negedge clk);
      idle_inputs();
      check_pair(1'b1, e[0], e[1], "R8 same-cycle pair 0");
      @(negedge clk);
      check_pair(1'b1, e[2], e[3], "R8 same-cycle pair 1");
      @(negedge clk);
      check_pair(1'b0, '0, '0, "R5 idle after collision");
    end

    // R8: read one cycle after a write to the same address
    begin : follow
      logic [DW-1:0] e [4];
      @(negedge clk);
      wr_sel_n = 1'b0; addr = 4'hA; wr_rise = pat(16'h3C3C, 0); wr_fall = pat(16'h3C3C, 1);
      be_rise_n = '0; be_fall_n = '0;
      shadow_apply(4'hA, 16'h3C3C, 16'h0000);
      for (int b = 0; b < 4; b++) e[b] = shadow[{4'hA, 2'(b)}];
      @(negedge clk);
      wr_sel_n = 1'b1; rd_sel_n = 1'b0; addr = 4'hA;
      wr_rise = pat(16'h3C3C, 2); wr_fall = pat(16'h3C3C, 3);
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      check_pair(1'b1, e[0], e[1], "R8 follow-on pair 0");
      @(negedge clk);
      check_pair(1'b1, e[2], e[3], "R8 follow-on pair 1");
    end

    // R9: reset asserted while a read is in flight
    @(negedge clk); rd_sel_n = 1'b0; addr = 4'h3;
    @(negedge clk); idle_inputs(); rst_n = 1'b0;
    @(negedge clk);
    check_pair(1'b0, '0, '0, "R9 reset during read");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pair(1'b0, '0, '0, "R9 after mid-burst reset");
    read_check(4'h3, "R9 read after reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule